// File: doc/BRIEF.md
# Serial IO Configuration Chain Loader

This controller fills a 40-bit serial-in, parallel-out configuration chain built from five cascaded 8-bit shift stages. Every update shifts one complete 40-bit frame over a serial clock and data pair, then raises a latch strobe. The strobe copies the shifted frame onto the stage outputs. Of the 40 bits, 32 set the direction of the IO pins and the top 8 carry an analog gain word.

On the host side the block takes a 32-bit direction vector, one bit per pin, and an 8-bit gain word, and starts an update on a single-cycle load request. Before it moves any bit, it reorders the direction vector into chain order. Within every byte of the vector the two nibbles are swapped.

After reset the block runs a protected start-up sequence. The stage outputs stay tristated and the serial stages are cleared. A frame of all zeros is then shifted in and latched. Only after that does the output enable go active. This way the downstream drivers never see an undefined pattern.

Top module: `cfg_chain_loader`

## Requirements
- R1: While `rst_n` is low, `oe_n_o` and `busy_o` are 1, `sclr_n_o` is 0, and `sclk_o` and `latch_o` are 0. `sclr_n_o` is driven low only while `oe_n_o` is high, and it returns high after the first serial clock phase.
- R2: After reset the block shifts 40 zero bits and latches them, with no host request needed. As a result, the first latched frame is all zero.
- R3: `oe_n_o` falls only in the cycle after the start-up latch pulse ends. Once low, it stays low until the next reset.
- R4: Each update produces exactly 40 rising edges of `sclk_o` before its latch pulse, and chain bit 39 is sent first. `sdata_o` changes only while `sclk_o` is low, so it is stable at every rising edge.
- R5: Successive rising edges of `sclk_o` within one update are 2*HALF_DIV system clock cycles apart.
- R6: Let direction bit p (p = 0..31) stand for pin p+1. Within each byte of the vector the nibbles are swapped into the chain: chain bit 8k+j takes `dir_i[8k+j+4]` for j < 4, and takes `dir_i[8k+j-4]` for j >= 4. For example, pin 1 goes to chain bit 4, pin 5 to bit 0, and pin 32 to bit 27. A 1 turns the pin's output driver on.
- R7: Chain bits 32..39 carry `gain_i[0]`..`gain_i[7]`, so gain bit 0 lands on chain bit 32.
- R8: The latch pulse starts after the last serial bit, once `sclk_o` is back low. It lasts at least 2*HALF_DIV cycles, and `sclk_o` stays low for the whole pulse.
- R9: `busy_o` is high from the cycle after a load request until the latch pulse of that update ends.
- R10: A load request that arrives while busy is held and served after the current update completes, and it does not interrupt that update. Any requests that arrive during one update are merged into one, using the data of the latest request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 32 | Per-pin direction, bit p is pin p+1, 1 = output |
| gain_i | input | 8 | Analog gain word |
| load_i | input | 1 | Single-cycle update request, captures dir_i and gain_i |
| busy_o | output | 1 | Start-up sequence or update in progress |
| sclk_o | output | 1 | Serial shift clock to the chain |
| sdata_o | output | 1 | Serial data to the chain, MSB first |
| latch_o | output | 1 | Parallel latch strobe, rising edge copies the frame |
| oe_n_o | output | 1 | Active-low output enable of the chain |
| sclr_n_o | output | 1 | Active-low clear of the serial stages |

## Verification
The bench feeds a behavioural model of the chain and compares each latched frame with a frame built independently from the requirement text. The patterns are chosen so that each one catches a different fault:
- A lone pin 1, a lone pin 5 and a lone pin 32 each land in a different nibble position. A missing or reversed nibble swap, or a byte-order mistake, moves the set bit to the wrong place.
- A gain word with only bit 0 set exposes any offset or reversal in the gain field.
- All-ones and random frames catch bit-order and bit-count errors across the whole chain.
- A second request issued in the middle of an update shows whether requests are held and served in order or cut into the frame in flight.

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
  parameter int HALF_DIV = 2,
  parameter int NPIN     = 32,
  parameter int GAIN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   dir_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              latch_o,
  output logic              oe_n_o,
  output logic              sclr_n_o
);
  localparam int CHAIN_W = NPIN + GAIN_W;
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W   = $clog2(CHAIN_W);

  typedef enum logic [1:0] {S_CLR, S_SHIFT, S_LATCH, S_IDLE} st_t;

  st_t                st;
  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic               lat_cnt;
  logic               pend;
  logic [CHAIN_W-1:0] sreg, nxt, map_frame;
  logic               tick;

  assign tick    = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign busy_o  = (st != S_IDLE);
  assign sdata_o = sreg[CHAIN_W-1];

  always_comb begin
    map_frame = '0;
    for (int p = 0; p < NPIN; p++) begin
      if ((p % 8) < 4) map_frame[p + 4] = dir_i[p];
      else             map_frame[p - 4] = dir_i[p];
    end
    map_frame[CHAIN_W-1:NPIN] = gain_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CLR;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      lat_cnt  <= 1'b0;
      pend     <= 1'b0;
      sreg     <= '0;
      nxt      <= '0;
      sclk_o   <= 1'b0;
      latch_o  <= 1'b0;
      oe_n_o   <= 1'b1;
      sclr_n_o <= 1'b0;
    end else begin
      if (load_i) nxt <= map_frame;
      if (load_i && st != S_IDLE) pend <= 1'b1;
      if (st == S_IDLE) div_cnt <= '0;
      else div_cnt <= tick ? '0 : div_cnt + 1'b1;
      case (st)
        S_CLR: if (tick) begin
          sclr_n_o <= 1'b1;
          sreg     <= '0;
          bit_cnt  <= '0;
          st       <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sclk_o) sclk_o <= 1'b1;
          else begin
            sclk_o <= 1'b0;
            sreg   <= sreg << 1;
            if (bit_cnt == BIT_W'(CHAIN_W - 1)) begin
              st      <= S_LATCH;
              latch_o <= 1'b1;
              lat_cnt <= 1'b0;
            end else bit_cnt <= bit_cnt + 1'b1;
          end
        end
        S_LATCH: if (tick) begin
          if (lat_cnt) begin
            latch_o <= 1'b0;
            oe_n_o  <= 1'b0;
            if (pend || load_i) begin
              sreg    <= load_i ? map_frame : nxt;
              pend    <= 1'b0;
              bit_cnt <= '0;
              div_cnt <= '0;
              st      <= S_SHIFT;
            end else st <= S_IDLE;
          end else lat_cnt <= 1'b1;
        end
        default: if (load_i || pend) begin
          sreg    <= load_i ? map_frame : nxt;
          pend    <= 1'b0;
          bit_cnt <= '0;
          div_cnt <= '0;
          st      <= S_SHIFT;
        end
      endcase
    end
  end

  p_clr_tristate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sclr_n_o |-> oe_n_o);
  p_oe_after_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n_o) |-> $past(latch_o));
  p_oe_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |=> !oe_n_o);
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdata_o));
  p_latch_sclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> !sclk_o);
  p_latch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> busy_o);
endmodule

// File: tb/cfg_chain_loader_tb_top.sv
module cfg_chain_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;

  logic clk = 1'b0, rst_n = 1'b0, load_i = 1'b0;
  logic [31:0] dir_i = '0;
  logic [7:0]  gain_i = '0;
  logic busy_o, sclk_o, sdata_o, latch_o, oe_n_o, sclr_n_o;

  cfg_chain_loader #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .gain_i(gain_i), .load_i(load_i),
    .busy_o(busy_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .latch_o(latch_o),
    .oe_n_o(oe_n_o), .sclr_n_o(sclr_n_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int rises = 0, rises_at_latch = 0, last_rise = 0, per_bad = 0;
  int lw = 0, last_lw = 0, latch_cnt = 0, latch_at_oe = -1;
  logic [39:0] m_sr = '0, m_out = '0;
  logic [39:0] lat_log [0:63];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sclk_o or negedge sclr_n_o) begin
    if (!sclr_n_o) m_sr <= '0;
    else begin
      m_sr <= {m_sr[38:0], sdata_o};
      if (rises > 0 && (cyc - last_rise) != 2*HALF_DIV) per_bad++;
      last_rise = cyc;
      rises++;
    end
  end

  always @(posedge latch_o) begin
    m_out = m_sr;
    if (latch_cnt < 64) lat_log[latch_cnt] = m_sr;
    latch_cnt++;
    rises_at_latch = rises;
    rises = 0;
  end

  always @(negedge oe_n_o) if (rst_n) latch_at_oe = latch_cnt;

  always @(negedge clk) begin
    if (latch_o) lw++;
    else if (lw != 0) begin last_lw = lw; lw = 0; end
  end

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_frame(input logic [31:0] d, input logic [7:0] g);
    logic [39:0] f = '0;
    for (int p = 0; p < 32; p++) begin
      int w = p % 8;
      int b = (p / 8) * 8 + ((w < 4) ? w + 4 : w - 4);
      f[b] = d[p];
    end
    f[39:32] = g;
    return f;
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (busy_o);
    @(negedge clk);
  endtask

  task automatic update(input logic [31:0] d, input logic [7:0] g, input string tag);
    logic [39:0] e = exp_frame(d, g);
    @(negedge clk);
    dir_i = d; gain_i = g; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after request", 40'(busy_o), 40'd1);
    wait_idle();
    check(m_out == e, tag, m_out, e);
    check(rises_at_latch == 40, "R4 rising edges per update", 40'(rises_at_latch), 40'd40);
    check(last_lw >= 2*HALF_DIV, "R8 latch width", 40'(last_lw), 40'(2*HALF_DIV));
    check(per_bad == 0, "R5 sclk period", 40'(per_bad), 40'd0);
    check(busy_o == 1'b0, "R9 busy clear after latch", 40'(busy_o), 40'd0);
  endtask

  initial begin
    if (cyc >= 0) begin : watchdog
      fork
        begin
          repeat (100000) @(posedge clk);
          fails++;
          $display("FAIL R9 watchdog expired actual=running expected=done");
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      join_none
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(oe_n_o == 1'b1 && sclr_n_o == 1'b0 && sclk_o == 1'b0 && latch_o == 1'b0 && busy_o == 1'b1,
          "R1 reset state", {35'd0, oe_n_o, sclr_n_o, sclk_o, latch_o, busy_o}, 40'b10001);
    rst_n = 1'b1;
    wait_idle();
    check(sclr_n_o == 1'b1, "R1 clear released", 40'(sclr_n_o), 40'd1);
    check(latch_cnt == 1 && lat_log[0] == '0, "R2 start-up zero frame", lat_log[0], 40'd0);
    check(rises_at_latch == 40, "R2 start-up shift count", 40'(rises_at_latch), 40'd40);
    check(oe_n_o == 1'b0, "R3 enable after start-up", 40'(oe_n_o), 40'd0);
    check(latch_at_oe == 1, "R3 enable only after zero latch", 40'(latch_at_oe), 40'd1);

    update(32'h0000_0001, 8'h00, "R6 pin 1 to chain bit 4");
    check(m_out == 40'h10, "R6 pin 1 literal", m_out, 40'h10);
    update(32'h0000_0010, 8'h00, "R6 pin 5 to chain bit 0");
    check(m_out == 40'h1, "R6 pin 5 literal", m_out, 40'h1);
    update(32'h8000_0000, 8'h00, "R6 pin 32 to chain bit 27");
    check(m_out == 40'h1 << 27, "R6 pin 32 literal", m_out, 40'h1 << 27);
    update(32'h0000_0000, 8'h01, "R7 gain bit 0 to chain bit 32");
    check(m_out == 40'h1 << 32, "R7 gain literal", m_out, 40'h1 << 32);
    update(32'hFFFF_FFFF, 8'hFF, "R4 all ones frame");
    update(32'h1234_5678, 8'hA5, "R6 R7 mixed frame");

    begin : overlap_r10
      int n0;
      logic [39:0] ea, eb;
      ea = exp_frame(32'hDEAD_BEEF, 8'h3C);
      eb = exp_frame(32'h0F0F_00FF, 8'hC3);
      n0 = latch_cnt;
      @(negedge clk);
      dir_i = 32'hDEAD_BEEF; gain_i = 8'h3C; load_i = 1'b1;
      @(negedge clk); load_i = 1'b0;
      repeat (30) @(negedge clk);
      dir_i = 32'h1111_1111; gain_i = 8'h11; load_i = 1'b1;
      @(negedge clk);
      dir_i = 32'h0F0F_00FF; gain_i = 8'hC3;
      @(negedge clk); load_i = 1'b0;
      wait_idle();
      check(latch_cnt == n0 + 2, "R10 held request served once", 40'(latch_cnt - n0), 40'd2);
      check(lat_log[n0] == ea, "R10 first update not interrupted", lat_log[n0], ea);
      check(lat_log[n0+1] == eb, "R10 latest data wins", lat_log[n0+1], eb);
      check(m_out == eb, "R10 final output", m_out, eb);
    end

    for (int i = 0; i < 12; i++) begin
      logic [31:0] d = $urandom;
      logic [7:0]  g = 8'($urandom);
      update(d, g, "R6 R7 random frame");
    end
    check(oe_n_o == 1'b0, "R3 enable stays low", 40'(oe_n_o), 40'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule